// File: doc/BRIEF.md
# ADPCM All-Zero Code Detector

This block watches the serial ADPCM input of each channel and raises a flag when a frame carries the 4-bit code made only of zeros. All channels share one ADPCM bit clock. Each channel has its own frame sync, serial data bit and through-mode input. A sync pulse marks the start of a frame. The first bits after it are collected, and on the clock edge that takes in the last bit of the code the flag for that channel is updated.

The flag rises when the whole code is zero and falls when any bit of it is one. Between two update edges the flag holds its value. When consecutive frames all carry the zero code, the flag stays high with no gap. Bits that arrive after the code, before the next sync, are ignored.

When a channel is in through mode, its flag is forced low and any frame being collected is dropped. The channel then waits for a fresh sync. The number of channels and the code width are parameters.

Top module: `adpcm_zero_detect`

## Requirements
- R1: When all CODE_BITS bits of a frame's code are 0, the channel's flag is 1 after the rising edge that samples the last code bit.
- R2: When any code bit of a frame is 1, the channel's flag is 0 after the rising edge that samples the last code bit.
- R3: The flag changes only on an edge that samples the last code bit of a frame, or on an edge where through mode is active.
- R4: When consecutive frames each carry the all-zero code, the flag stays 1 in every cycle between them.
- R5: While a channel's through input is 1, its flag is 0 from the next edge on. A frame that through mode interrupts produces no update, even if the remaining bits arrive after through mode ends.
- R6: A sync bit sampled high at a rising edge makes the data bit sampled at that same edge bit 1 (the MSB) of a new code. A sync that arrives during a code restarts collection and discards the earlier bits.
- R7: Data bits sampled after the last code bit and before the next sync have no effect on the flag.
- R8: Channels are independent. One channel's sync, data and through inputs never affect another channel's flag.
- R9: While rst_n is 0, and right after it is released, every flag is 0 and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADPCM bit clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| syncIn | input | NUM_CH | Per-channel frame sync; high at an edge marks code bit 1 |
| serIn | input | NUM_CH | Per-channel serial ADPCM data, MSB first |
| thruEn | input | NUM_CH | Per-channel through mode; 1 disables detection |
| detFlag | output | NUM_CH | Per-channel all-zero code flag |

## Verification
Two collisions matter here. A sync can land on the edge where the last code bit is due, and through mode can be raised in the middle of a frame or on its update edge. Directed sequences place a second sync on the third bit slot, and pulse through mode at the third bit of a zero frame before letting the remaining zeros arrive. The bench judges each case against a cycle-level reference model and against explicit expected flag values. A long seeded random run then drives independent sync, data and through patterns on both channels, so that these coincidences also occur unplanned.

// File: rtl/zcd_pkg.sv
package zcd_pkg;

  // Strobes from the frame control to the code datapath of one channel
  typedef struct packed {
    logic clear;   // through mode: drop frame, force flag low
    logic start;   // sync edge: sampled bit is code bit 1
    logic shift;   // middle code bit
    logic last;    // final code bit: update flag
  } zcdStrobe_t;

endpackage

// File: rtl/zcd_ctrl.sv
module zcd_ctrl
  import zcd_pkg::*;
#(
  parameter int CODE_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       syncIn,
  input  logic       thruEn,
  output zcdStrobe_t strobe
);

  localparam int CNT_W = $clog2(CODE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CODE_BITS - 1);
  localparam logic [CNT_W-1:0] FIRST_IDX = CNT_W'(1);

  // bitCnt = number of code bits already taken; 0 means idle
  logic [CNT_W-1:0] bitCnt;
  logic inFrame;

  assign inFrame = (bitCnt != '0);

  always_comb begin
    strobe.clear = thruEn;
    strobe.start = syncIn && !thruEn;
    strobe.shift = !syncIn && !thruEn && inFrame && (bitCnt < LAST_IDX);
    strobe.last  = !syncIn && !thruEn && (bitCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitCnt <= '0;
    end else if (strobe.clear) begin
      bitCnt <= '0;
    end else if (strobe.start) begin
      bitCnt <= FIRST_IDX;
    end else if (strobe.shift) begin
      bitCnt <= bitCnt + FIRST_IDX;
    end else if (strobe.last) begin
      bitCnt <= '0;
    end
  end

  // R6
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syncIn && !thruEn) |=> (bitCnt == FIRST_IDX));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitCnt == '0 && !syncIn) |-> !(strobe.shift || strobe.last));

  // R5
  thru_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thruEn |=> (bitCnt == '0));

endmodule

// File: rtl/zcd_datapath.sv
module zcd_datapath
  import zcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serBit,
  input  zcdStrobe_t strobe,
  output logic       detFlag
);

  // OR of code bits taken so far in the current frame
  logic anyOne;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      anyOne  <= 1'b0;
      detFlag <= 1'b0;
    end else if (strobe.clear) begin
      anyOne  <= 1'b0;
      detFlag <= 1'b0;
    end else if (strobe.start) begin
      anyOne <= serBit;
    end else if (strobe.shift) begin
      anyOne <= anyOne | serBit;
    end else if (strobe.last) begin
      detFlag <= !(anyOne | serBit);
      anyOne  <= 1'b0;
    end
  end

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.last || strobe.clear) |=> $stable(detFlag));

  // R4
  zero_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (detFlag && strobe.last && !anyOne && !serBit) |=> detFlag);

endmodule

// File: rtl/adpcm_zero_detect.sv
module adpcm_zero_detect
  import zcd_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CODE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] syncIn,
  input  logic [NUM_CH-1:0] serIn,
  input  logic [NUM_CH-1:0] thruEn,
  output logic [NUM_CH-1:0] detFlag
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    zcdStrobe_t strobe;

    zcd_ctrl #(.CODE_BITS(CODE_BITS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .syncIn (syncIn[c]),
      .thruEn (thruEn[c]),
      .strobe (strobe)
    );

    zcd_datapath u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .serBit  (serIn[c]),
      .strobe  (strobe),
      .detFlag (detFlag[c])
    );

    // R5
    thru_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thruEn[c] |=> !detFlag[c]);
  end

endmodule

// File: tb/adpcm_zero_detect_test.sv
module adpcm_zero_detect_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] syncIn, serIn, thruEn, detFlag;

  always #(CLK_PERIOD/2) clk = ~clk;

  adpcm_zero_detect #(.NUM_CH(NCH), .CODE_BITS(4)) uut (
    .clk(clk), .rst_n(rst_n), .syncIn(syncIn), .serIn(serIn),
    .thruEn(thruEn), .detFlag(detFlag)
  );

  int errors = 0;
  int checks = 0;
  string curReq = "R9";

  // Reference model built from the requirements (code width 4)
  int   mCnt [NCH];
  logic mAny [NCH];
  logic mFlag[NCH];

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n || thruEn[c]) begin
        mCnt[c] = 0; mAny[c] = 1'b0; mFlag[c] = 1'b0;
      end else if (syncIn[c]) begin
        mCnt[c] = 1; mAny[c] = serIn[c];
      end else if (mCnt[c] == 1 || mCnt[c] == 2) begin
        mCnt[c] = mCnt[c] + 1; mAny[c] = mAny[c] | serIn[c];
      end else if (mCnt[c] == 3) begin
        mFlag[c] = !(mAny[c] | serIn[c]); mCnt[c] = 0;
      end
    end
  end

  function automatic logic expZero(input logic [3:0] code);
    return (code == 4'b0000);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One bit period: drive after a falling edge, compare at the next one
  task automatic cyc(input logic [1:0] s, input logic [1:0] b, input logic [1:0] t);
    syncIn = s; serIn = b; thruEn = t;
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) chk(curReq, $sformatf("model ch%0d", c), detFlag[c], mFlag[c]);
  endtask

  // Frame on both channels, then gap cycles carrying given filler bits
  task automatic frame(input string req, input logic [3:0] c0, input logic [3:0] c1,
                       input int gap, input logic [1:0] fill);
    for (int i = 0; i < 4; i++)
      cyc((i == 0) ? 2'b11 : 2'b00, {c1[3-i], c0[3-i]}, 2'b00);
    chk(req, "ch0 update", detFlag[0], expZero(c0));
    chk(req, "ch1 update", detFlag[1], expZero(c1));
    for (int g = 0; g < gap; g++) cyc(2'b00, fill, 2'b00);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; syncIn = '0; serIn = '0; thruEn = '0;
    repeat (3) @(negedge clk);
    chk("R9", "ch0 in reset", detFlag[0], 1'b0);
    chk("R9", "ch1 in reset", detFlag[1], 1'b0);
    rst_n = 1'b1;
    cyc(2'b00, 2'b11, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    chk("R9", "ch0 after reset", detFlag[0], 1'b0);

    // R1 R2 R8: zero on one channel, non-zero on the other, then swapped
    curReq = "R8";
    frame("R1", 4'b0000, 4'b0101, 2, 2'b00);
    frame("R2", 4'b1000, 4'b0000, 2, 2'b00);

    // R2: a single one in each position
    curReq = "R2";
    for (int p = 0; p < 4; p++) frame("R2", 4'b0001 << p, 4'b0001 << (3 - p), 1, 2'b00);

    // R3 R7: hold across a long gap full of ones
    curReq = "R7";
    frame("R1", 4'b0000, 4'b0000, 6, 2'b11);
    chk("R7", "ch0 after ones gap", detFlag[0], 1'b1);
    chk("R3", "ch1 held in gap", detFlag[1], 1'b1);

    // R4: back-to-back zero frames keep the flag high every cycle
    curReq = "R4";
    frame("R4", 4'b0000, 4'b0000, 0, 2'b00);
    frame("R4", 4'b0000, 4'b0000, 0, 2'b00);
    frame("R4", 4'b0000, 4'b1111, 1, 2'b00);

    // R5: through mode clears, and an interrupted frame yields nothing
    curReq = "R5";
    cyc(2'b00, 2'b00, 2'b01);
    chk("R5", "ch0 cleared by through", detFlag[0], 1'b0);
    frame("R1", 4'b0000, 4'b0000, 1, 2'b00);
    cyc(2'b11, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b11);
    chk("R5", "ch0 through mid frame", detFlag[0], 1'b0);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    chk("R5", "ch0 no update after through", detFlag[0], 1'b0);
    chk("R5", "ch1 no update after through", detFlag[1], 1'b0);

    // R6: a second sync on the third bit slot restarts the code
    curReq = "R6";
    cyc(2'b11, 2'b11, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    frame("R6", 4'b0000, 4'b0010, 1, 2'b00);
    // sync on the slot where the last bit was due: no update there
    cyc(2'b11, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b11, 2'b11, 2'b00);
    chk("R6", "ch0 held at late sync", detFlag[0], 1'b1);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    chk("R6", "ch0 restarted code", detFlag[0], 1'b0);

    // Random stream: independent sync, data and through per channel
    curReq = "R1";
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s, b, t;
      for (int c = 0; c < NCH; c++) begin
        s[c] = ($urandom_range(0, 5) == 0);
        b[c] = ($urandom_range(0, 9) < 3);
        t[c] = ($urandom_range(0, 59) == 0);
      end
      cyc(s, b, t);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule